// File: doc/BRIEF.md
# Fast UART Register Bank

This block is the processor-facing side of a fast UART that always frames characters as eight data bits, no parity and one stop bit. A 32-bit bus reaches five word registers: a data port, a level register, an event status register, a control word and a baud-divider byte. Serial shifting, baud timing and trigger detection live outside. The serializer pushes received characters, each tagged with framing-error and break flags, into a receive queue. It pulls bytes to send from a transmit queue. It reports events through single-cycle pulses and two level inputs.

Software drains received data by reading the data port until the returned word carries the empty flag. Each non-empty read returns one character and its tags and removes it from the queue. Writes to the data port queue a byte for transmission. Event bits latch until software writes 1 to them. A single interrupt line combines the latched events with three enable bits in the control word.

Top module: `fub_regbank`

## Requirements
- R1: After reset the level, status and control registers read 0, the rate register reads 0x000000FF, `irq` is 0 and `tx_avail` is 0.
- R2: A read of offset 0x00 with received data pending returns the oldest character in bits 7:0, bit 8 as 0, its framing-error tag in bit 9 and its break tag in bit 10, with bits 31:11 zero. It removes that character, so characters leave in arrival order.
- R3: A read of offset 0x00 with the receive queue empty returns 0x00000100 and leaves every register unchanged.
- R4: A write to offset 0x00 queues `bus_wdata[7:0]` for transmission. `tx_avail` is high while bytes are queued and `tx_byte` shows the oldest one, and a `tx_pop` cycle removes it. A write while 64 bytes are queued, with no pop in the same cycle, is ignored.
- R5: Offset 0x04 reads the transmit queue count in bits 15:8 and the receive queue count in bits 7:0, with other bits zero.
- R6: A receive push while 64 characters are queued, with no read pop in the same cycle, drops the character and sets status bit 5 (overrun).
- R7: Status bits 0 (transmit request), 3 (framing error) and 4 (break) latch on `ev_tx_req`, `ev_frame` and `ev_break`. These bits and bit 5 clear when 1 is written to them at offset 0x08. Writing 0 leaves them alone, and a set in the same cycle as a clear wins.
- R8: Status bit 1 follows `rx_trig` and bit 2 follows `rx_tmo` in the same cycle, and writes to these bits have no effect.
- R9: Writing 1 to status bit 6 sets the transmit-request latch in bit 0. Bit 6 always reads 0.
- R10: Offset 0x0C stores and returns a full 32-bit control word. Offset 0x10 stores `bus_wdata[7:0]` and returns it in bits 7:0 with upper bits zero. `ctrl_word` and `rate_div` show the stored values.
- R11: `irq` = (status bit 0 AND control bit 5) OR ((`rx_trig` OR `rx_tmo`) AND control bit 6) OR ((status bit 3, 4 or 5) AND control bit 7).
- R12: An access to an unaligned address or to offsets 0x14 to 0x1C reads 0, and has no effect when written. An unaligned read also does not pop the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_push | input | 1 | Received character valid |
| rx_char | input | 8 | Received character |
| rx_ferr | input | 1 | Framing-error tag of the received character |
| rx_brk | input | 1 | Break tag of the received character |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| ev_tx_req | input | 1 | Pulse: transmitter wants more data |
| ev_frame | input | 1 | Pulse: framing error seen |
| ev_break | input | 1 | Pulse: break seen |
| rx_trig | input | 1 | Level: receive trigger level reached |
| rx_tmo | input | 1 | Level: receive inactivity timeout |
| ctrl_word | output | 32 | Stored control word |
| rate_div | output | 8 | Stored baud divider |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a queue depth of 64 and a 5-bit byte address. These values put both queue-full boundaries within a few hundred cycles, so the bench can fill and drain each queue completely. The bench overfills the receive queue to raise overrun and overfills the transmit queue to show the ignored writes. With the 5-bit address, the three unmapped word slots and unaligned offsets can also be hit directly.

// File: rtl/fub_pkg.sv
// Shared constants for the fast UART register bank.
// Assumes word registers decoded from byte-address bits above bit 1.
package fub_pkg;
    localparam logic [2:0] IDX_DATA  = 3'd0;
    localparam logic [2:0] IDX_LEVEL = 3'd1;
    localparam logic [2:0] IDX_ISR   = 3'd2;
    localparam logic [2:0] IDX_CTRL  = 3'd3;
    localparam logic [2:0] IDX_RATE  = 3'd4;

    // status bit positions
    localparam int ST_TX   = 0;
    localparam int ST_TRIG = 1;
    localparam int ST_TMO  = 2;
    localparam int ST_FE   = 3;
    localparam int ST_BRK  = 4;
    localparam int ST_OE   = 5;
    localparam int ST_TXSET = 6;

    // control enables
    localparam int CT_TXIE  = 5;
    localparam int CT_RXIE  = 6;
    localparam int CT_ERRIE = 7;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic [7:0] chr;
    } rx_word_t;
endpackage

// File: rtl/fub_fifo.sv
// Synchronous FIFO with occupancy count.
// A push is taken when not full, or when a pop happens in the same cycle.
// A pop on empty is ignored; a refused push raises 'dropped' for that cycle.
module fub_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          dropped
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dropped = push && !push_ok;
    assign dout    = mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6 / R4: a push into a full queue without a pop leaves the count alone
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/fub_evlatch.sv
// Bank of sticky event latches: set has priority over write-one clear.
module fub_evlatch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // latch update, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= set | (q & ~clr);
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: a clear with no set drops the latch
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
        // R7: a set always leaves the latch high
        assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
    end
endmodule

// File: rtl/fub_regbank.sv
// Register bank of a fast 8N1 UART: tagged receive queue, transmit queue,
// sticky event status, control word, baud divider and one interrupt line.
// Assumes one-cycle bus strobes; read data is combinational in that cycle.
module fub_regbank
    import fub_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 5,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          rx_push,
    input  logic [7:0]    rx_char,
    input  logic          rx_ferr,
    input  logic          rx_brk,
    input  logic          tx_pop,
    output logic [7:0]    tx_byte,
    output logic          tx_avail,
    input  logic          ev_tx_req,
    input  logic          ev_frame,
    input  logic          ev_break,
    input  logic          rx_trig,
    input  logic          rx_tmo,
    output logic [31:0]   ctrl_word,
    output logic [7:0]    rate_div,
    output logic          irq
);
    logic          aligned, rd_en, wr_en;
    logic [IW-1:0] widx;
    logic          sel_data, sel_isr;
    rx_word_t      rx_in, rx_head;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_full, rx_empty, rx_drop, rx_pop;
    logic          tx_full, tx_empty, tx_drop, tx_push;
    logic [3:0]    lat_set, lat_clr, lat_q;   // 0 tx, 1 fe, 2 brk, 3 oe
    logic [31:0]   ctrl_q;
    logic [7:0]    rate_q;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign widx     = bus_addr[AW-1:2];
    assign rd_en    = bus_sel && !bus_wr && aligned;
    assign wr_en    = bus_sel &&  bus_wr && aligned;
    assign sel_data = (widx == IW'(IDX_DATA));
    assign sel_isr  = (widx == IW'(IDX_ISR));

    assign rx_in  = '{brk: rx_brk, fe: rx_ferr, chr: rx_char};
    assign rx_pop = rd_en && sel_data;
    assign tx_push = wr_en && sel_data;

    fub_fifo #(.W($bits(rx_word_t)), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_in), .pop(rx_pop),
        .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .dropped(rx_drop));

    fub_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_byte), .count(tx_cnt), .full(tx_full),
        .empty(tx_empty), .dropped(tx_drop));

    assign tx_avail = !tx_empty;

    // event latch set and write-one clear sources
    always_comb begin
        lat_set = {rx_drop, ev_break, ev_frame,
                   ev_tx_req | (wr_en && sel_isr && bus_wdata[ST_TXSET])};
        lat_clr = '0;
        if (wr_en && sel_isr)
            lat_clr = {bus_wdata[ST_OE], bus_wdata[ST_BRK],
                       bus_wdata[ST_FE], bus_wdata[ST_TX]};
    end

    fub_evlatch #(.N(4)) u_lat (
        .clk(clk), .rst_n(rst_n), .set(lat_set), .clr(lat_clr), .q(lat_q));

    // control word and baud divider storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rate_q <= 8'hFF;
        end else if (wr_en) begin
            if (widx == IW'(IDX_CTRL)) ctrl_q <= bus_wdata;
            if (widx == IW'(IDX_RATE)) rate_q <= bus_wdata[7:0];
        end
    end

    assign ctrl_word = ctrl_q;
    assign rate_div  = rate_q;

    // read data selection
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IW'(IDX_DATA):  bus_rdata = rx_empty ? 32'h0000_0100
                                          : {21'd0, rx_head.brk, rx_head.fe, 1'b0, rx_head.chr};
                IW'(IDX_LEVEL): bus_rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
                IW'(IDX_ISR):   bus_rdata = {26'd0, lat_q[3], lat_q[2], lat_q[1],
                                             rx_tmo, rx_trig, lat_q[0]};
                IW'(IDX_CTRL):  bus_rdata = ctrl_q;
                IW'(IDX_RATE):  bus_rdata = {24'd0, rate_q};
                default:        bus_rdata = '0;
            endcase
        end
    end

    // interrupt combination
    assign irq = (lat_q[0] & ctrl_q[CT_TXIE])
               | ((rx_trig | rx_tmo) & ctrl_q[CT_RXIE])
               | ((|lat_q[3:1]) & ctrl_q[CT_ERRIE]);

    // R3: empty data read returns only the empty flag
    assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(0) && rx_empty) |-> (bus_rdata == 32'h100));
    // R6: a dropped receive push shows up as overrun next cycle
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop) |=> bus_rdata_isr_oe());
    // R11: with all enables clear the line stays low
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7:5] == 3'b000) |-> !irq);
    // R4: a refused transmit write leaves the queue full
    assert_tx_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop) |=> tx_full);

    function automatic logic bus_rdata_isr_oe();
        return lat_q[3];
    endfunction
endmodule

// File: tb/fub_regbank_tb_top.sv
// Self-checking bench with a behavioural queue model compared every clock.
module fub_regbank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        sel = 0, wr = 0;
    logic [4:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic        rx_push = 0, rx_ferr = 0, rx_brk = 0, tx_pop = 0;
    logic [7:0]  rx_char = 0;
    logic        ev_tx = 0, ev_fe = 0, ev_brk = 0, trig = 0, tmo = 0;
    logic [31:0] rdata, ctrl_word;
    logic [7:0]  tx_byte, rate_div;
    logic        tx_avail, irq;

    fub_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .rx_push(rx_push), .rx_char(rx_char),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .tx_avail(tx_avail), .ev_tx_req(ev_tx), .ev_frame(ev_fe), .ev_break(ev_brk),
        .rx_trig(trig), .rx_tmo(tmo), .ctrl_word(ctrl_word), .rate_div(rate_div),
        .irq(irq));

    // reference model state
    logic [9:0]  m_rx[$];
    logic [7:0]  m_tx[$];
    logic [3:0]  m_lat = 0;     // 0 tx, 1 fe, 2 brk, 3 oe
    logic [31:0] m_ctrl = 0;
    logic [7:0]  m_rate = 8'hFF;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return (m_rx.size() == 0) ? 32'h100
                         : {21'd0, m_rx[0][9], m_rx[0][8], 1'b0, m_rx[0][7:0]};
            3'd1: return {16'd0, 8'(m_tx.size()), 8'(m_rx.size())};
            3'd2: return {26'd0, m_lat[3], m_lat[2], m_lat[1], tmo, trig, m_lat[0]};
            3'd3: return m_ctrl;
            3'd4: return {24'd0, m_rate};
            default: return 32'h0;
        endcase
    endfunction

    // one clock: check read data, advance model, compare outputs
    task automatic step(input string tag);
        bit rd, wt, rxp, txp, txw;
        logic [3:0] set, clr;
        #1;
        rd = sel && !wr && addr[1:0] == 0;
        wt = sel && wr && addr[1:0] == 0;
        if (sel && !wr) check(tag, rdata, exp_read(addr));
        rxp = rd && addr[4:2] == 0 && m_rx.size() > 0;
        txp = tx_pop && m_tx.size() > 0;
        txw = wt && addr[4:2] == 0 && (m_tx.size() < 64 || txp);
        set = 0; clr = 0;
        if (rxp) void'(m_rx.pop_front());
        if (rx_push) begin
            if (m_rx.size() < 64) m_rx.push_back({rx_brk, rx_ferr, rx_char});
            else set[3] = 1;
        end
        if (txp) void'(m_tx.pop_front());
        if (txw) m_tx.push_back(wdata[7:0]);
        set[0] = ev_tx | (wt && addr[4:2] == 2 && wdata[6]);
        set[1] = ev_fe;
        set[2] = ev_brk;
        if (wt && addr[4:2] == 2) clr = {wdata[5], wdata[4], wdata[3], wdata[0]};
        m_lat = set | (m_lat & ~clr);
        if (wt && addr[4:2] == 3) m_ctrl = wdata;
        if (wt && addr[4:2] == 4) m_rate = wdata[7:0];
        @(posedge clk);
        @(negedge clk);
        check("R11", {31'd0, irq}, {31'd0, (m_lat[0] & m_ctrl[5]) | ((trig | tmo) & m_ctrl[6])
                                           | ((|m_lat[3:1]) & m_ctrl[7])});
        check("R4", {31'd0, tx_avail}, {31'd0, m_tx.size() > 0});
        if (m_tx.size() > 0) check("R4", {24'd0, tx_byte}, {24'd0, m_tx[0]});
        check("R10", ctrl_word, m_ctrl);
        check("R10", {24'd0, rate_div}, {24'd0, m_rate});
        sel = 0; wr = 0; rx_push = 0; tx_pop = 0; ev_tx = 0; ev_fe = 0; ev_brk = 0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input string tag);
        sel = 1; wr = 0; addr = a; step(tag);
    endtask
    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input string tag);
        sel = 1; wr = 1; addr = a; wdata = d; step(tag);
    endtask
    task automatic rx_in(input logic [7:0] c, input logic f, input logic b, input string tag);
        rx_push = 1; rx_char = c; rx_ferr = f; rx_brk = b; step(tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step("R1");
        rd_reg(5'h04, "R1"); rd_reg(5'h08, "R1"); rd_reg(5'h0C, "R1"); rd_reg(5'h10, "R1");
        // R2 / R5 tagged receive words in order
        rx_in(8'h41, 0, 0, "R2"); rx_in(8'h5A, 1, 0, "R2"); rx_in(8'hC3, 1, 1, "R2");
        rd_reg(5'h04, "R5");
        for (int i = 0; i < 3; i++) rd_reg(5'h00, "R2");
        // R3 empty read leaves state alone
        rd_reg(5'h00, "R3"); rd_reg(5'h04, "R3"); rd_reg(5'h08, "R3");
        // R4 transmit queue, fill past full
        for (int i = 0; i < 66; i++) wr_reg(5'h00, 32'hAB00 + i, "R4");
        rd_reg(5'h04, "R5");
        for (int i = 0; i < 64; i++) begin tx_pop = 1; step("R4"); end
        tx_pop = 1; step("R4");
        // R6 receive overrun
        for (int i = 0; i < 66; i++) rx_in(8'(i * 3), i[0], i[1], "R6");
        rd_reg(5'h08, "R6"); rd_reg(5'h04, "R6");
        wr_reg(5'h08, 32'h20, "R6"); rd_reg(5'h08, "R6");
        for (int i = 0; i < 64; i++) rd_reg(5'h00, "R2");
        // R7 latches, write-zero, set beats clear
        ev_fe = 1; ev_brk = 1; ev_tx = 1; step("R7");
        rd_reg(5'h08, "R7");
        wr_reg(5'h08, 32'h0, "R7"); rd_reg(5'h08, "R7");
        ev_fe = 1; wr_reg(5'h08, 32'h08, "R7"); rd_reg(5'h08, "R7");
        wr_reg(5'h08, 32'h19, "R7"); rd_reg(5'h08, "R7");
        // R8 level-derived bits
        trig = 1; rd_reg(5'h08, "R8"); wr_reg(5'h08, 32'h06, "R8"); rd_reg(5'h08, "R8");
        trig = 0; tmo = 1; rd_reg(5'h08, "R8"); tmo = 0; rd_reg(5'h08, "R8");
        // R9 transmit-set bit
        wr_reg(5'h08, 32'h40, "R9"); rd_reg(5'h08, "R9");
        // R10 control and rate
        wr_reg(5'h0C, 32'hA5A5_A51F, "R10"); rd_reg(5'h0C, "R10");
        wr_reg(5'h10, 32'h0000_1234, "R10"); rd_reg(5'h10, "R10");
        // R11 interrupt combination
        wr_reg(5'h0C, 32'h20, "R11"); wr_reg(5'h08, 32'h01, "R11");
        wr_reg(5'h0C, 32'h40, "R11"); tmo = 1; step("R11"); tmo = 0; step("R11");
        wr_reg(5'h0C, 32'h80, "R11"); ev_brk = 1; step("R11");
        wr_reg(5'h08, 32'h10, "R11");
        // R12 unmapped and unaligned accesses
        rx_in(8'h77, 0, 0, "R12");
        rd_reg(5'h14, "R12"); rd_reg(5'h1C, "R12"); rd_reg(5'h01, "R12");
        wr_reg(5'h18, 32'hFFFF_FFFF, "R12"); wr_reg(5'h0D, 32'h0, "R12");
        wr_reg(5'h02, 32'h99, "R12");
        rd_reg(5'h0C, "R12"); rd_reg(5'h04, "R12"); rd_reg(5'h00, "R12");
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule